// File: doc/BRIEF.md
# Asynchronous Transmit Context Sequencer

This block runs one asynchronous transmit context of a serial-bus host controller. A start pulse makes it walk a linked list of descriptors in host memory. The list begins at an address fixed by a parameter, so a request context and a response context are two instances of the same logic with different list bases. For each descriptor the block does the following:

- It reads the whole four-word descriptor.
- It pulls the payload words into a local transmit FIFO.
- Once the FIFO holds the complete payload, it streams the packet to the link layer.
- It waits for the link's acknowledge code and replays the packet from its first word on a busy or retry acknowledge.
- It writes a completion status word back into the descriptor and pulses an interrupt.

The descriptor occupies four consecutive 32-bit words:

| Offset | Contents |
|---|---|
| +0 | Control. Bits [15:0] hold the payload word count and bit 31 is the last flag. |
| +4 | Payload address. |
| +8 | Branch address. Zero ends the list. |
| +12 | Status, written back by the block. |

The status word carries a result code in bits [3:0] and the number of retries used in bits [15:8]; all other bits are zero. Any error writes its status and then parks the context as dead until the next start.

The memory read request, the memory read response, the packet stream to the link and the status write are all valid/ready channels. A valid with its payload stays asserted and unchanged until the matching ready is seen high at a clock edge. `rd_rsp_ready` is high only while a response is awaited, and at most one read is outstanding. The link acknowledge is a single-cycle pulse. Start, interrupt and the three context status bits are plain pins.

Top module: `atx_ctx_seq`

## Requirements
- R1: After reset `ctx_idle` is 1, `ctx_active`, `ctx_dead` and `irq` are 0, and no valid output is asserted; at any time exactly one of `ctx_active`, `ctx_dead`, `ctx_idle` is 1.
- R2: A start pulse in the idle state reads the four descriptor words at LIST_BASE, +4, +8, +12 in that order, before any payload read.
- R3: The block reads exactly `count` payload words in ascending order from the payload address (step 4). It asserts `tx_valid` only when all of them are in the FIFO, then sends them in order with `tx_last` on the final word.
- R4: Acknowledge code 0 completes the descriptor with status code 1 written to descriptor address +12.
- R5: Acknowledge code 1 (busy) or 2 (retry) resends the whole payload from its first word, up to RETRY_MAX times; the status retry field holds the retries used.
- R6: A busy or retry acknowledge arriving when RETRY_MAX retries are already used ends the descriptor with status code 2 and the context dead.
- R7: A read response with its error flag set ends the descriptor at once with status code 3; no further read is issued and the branch address is not followed, and the context becomes dead.
- R8: Acknowledge code 3 ends the descriptor with status code 4 and the context dead.
- R9: A count of 0 or larger than DEPTH ends the descriptor with status code 5 and no payload read, and the context becomes dead.
- R10: After a successful descriptor, the block fetches the next descriptor at the branch address if the last flag is clear and the branch is non-zero; otherwise it returns to idle.
- R11: Each accepted status write is followed by exactly one single-cycle `irq` pulse, whether the descriptor succeeded or failed.
- R12: A start while dead clears the dead state and restarts from LIST_BASE; a start while active has no effect.
- R13: Every valid output holds its payload stable until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to start the context |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request accepted |
| rd_req_addr | output | WORD_W | Byte address of the word to read |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_ready | output | 1 | Block is waiting for a response |
| rd_rsp_data | input | WORD_W | Read response word |
| rd_rsp_err | input | 1 | Read response carries an error |
| tx_valid | output | 1 | Packet word to link valid |
| tx_ready | input | 1 | Link accepts packet word |
| tx_data | output | WORD_W | Packet word |
| tx_last | output | 1 | Final word of the packet |
| ack_valid | input | 1 | Single-cycle link acknowledge |
| ack_code | input | 2 | 0 done, 1 busy, 2 retry, 3 error |
| wr_valid | output | 1 | Status write valid |
| wr_ready | input | 1 | Status write accepted |
| wr_addr | output | WORD_W | Status word address |
| wr_data | output | WORD_W | Status word |
| irq | output | 1 | Descriptor completion pulse |
| ctx_active | output | 1 | Context is running |
| ctx_dead | output | 1 | Context stopped on an error |
| ctx_idle | output | 1 | Context idle without error |

## Verification
The handshake assertions assume that the memory, the link and the status sink never take back a ready-related promise. They also assume that a read response arrives only after its request was accepted, and that `ack_valid` pulses only once a packet's last word has been taken. The bench's stubs answer each read strictly after its request, one at a time. They fire the acknowledge two cycles after the last beat, and they toggle the ready inputs in a fixed pattern in the back-pressure test. A behavioural model walks the same descriptor list in memory and the acknowledge script to predict every read address, packet word and status write, and the bench compares each handshake against those predictions.

// File: rtl/atx_pkg.sv
package atx_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_DREQ, S_DRSP, S_PREQ, S_PRSP, S_SEND, S_WACK, S_WB
  } atx_state_e;

  // result codes written to status bits [3:0]
  localparam logic [3:0] CODE_OK    = 4'h1;
  localparam logic [3:0] CODE_RETRY = 4'h2;
  localparam logic [3:0] CODE_MEM   = 4'h3;
  localparam logic [3:0] CODE_LINK  = 4'h4;
  localparam logic [3:0] CODE_LEN   = 4'h5;

  // link acknowledge codes
  localparam logic [1:0] ACK_DONE  = 2'd0;
  localparam logic [1:0] ACK_BUSY  = 2'd1;
  localparam logic [1:0] ACK_RETRY = 2'd2;
  localparam logic [1:0] ACK_ERR   = 2'd3;

  localparam int CNT_W    = 16;  // payload count field width
  localparam int LAST_BIT = 31;  // last-descriptor flag in control word
endpackage

// File: rtl/atx_payload_buf.sv
module atx_payload_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rewind,
  input  logic          rd_adv,
  output logic [DW-1:0] rd_data,
  output logic [IW-1:0] wr_idx,
  output logic [IW-1:0] rd_idx
);
  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store_q[wr_idx[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
    end else if (clr) begin
      wr_idx <= '0;
      rd_idx <= '0;
    end else begin
      if (wr_en)  wr_idx <= wr_idx + 1'b1;
      if (rewind) rd_idx <= '0;
      else if (rd_adv) rd_idx <= rd_idx + 1'b1;
    end
  end

  assign rd_data = store_q[rd_idx[AW-1:0]];

  AST_BUF_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < IW'(DEPTH))); // R3
  AST_BUF_READ_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_adv |-> (rd_idx < wr_idx)); // R3
endmodule

// File: rtl/atx_retry_ctr.sv
module atx_retry_ctr #(
  parameter int RETRY_MAX = 3,
  localparam int RW = $clog2(RETRY_MAX + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [RW-1:0] count,
  output logic          spent
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  assign spent = (count == RW'(RETRY_MAX));

  AST_RETRY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> (count < RW'(RETRY_MAX))); // R6
endmodule

// File: rtl/atx_ctx_seq.sv
module atx_ctx_seq
  import atx_pkg::*;
#(
  parameter int          WORD_W    = 32,
  parameter int          DEPTH     = 8,
  parameter int          RETRY_MAX = 3,
  parameter logic [31:0] LIST_BASE = 32'h0000_1000,
  localparam int IW = $clog2(DEPTH + 1),
  localparam int RW = $clog2(RETRY_MAX + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [WORD_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [WORD_W-1:0] rd_rsp_data,
  input  logic              rd_rsp_err,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_last,
  input  logic              ack_valid,
  input  logic [1:0]        ack_code,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [WORD_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              irq,
  output logic              ctx_active,
  output logic              ctx_dead,
  output logic              ctx_idle
);
  atx_state_e        state_q;
  logic              dead_q, irq_q;
  logic [WORD_W-1:0] desc_q, ctrl_q, data_q, br_q;
  logic [1:0]        widx_q;
  logic [IW-1:0]     len_q;
  logic [3:0]        code_q;

  logic              desc_begin, buf_wr, buf_adv, retry_inc, spent, len_bad;
  logic [IW-1:0]     wr_idx, rd_idx;
  logic [RW-1:0]     retries;
  logic [WORD_W-1:0] buf_q;

  assign len_bad = (ctrl_q[CNT_W-1:0] == '0) || (ctrl_q[CNT_W-1:0] > CNT_W'(DEPTH));

  // new descriptor: from idle on start, or chained after a good write-back
  assign desc_begin = (state_q == S_IDLE && start) ||
                      (state_q == S_WB && wr_ready && code_q == CODE_OK &&
                       !ctrl_q[LAST_BIT] && br_q != '0);
  assign buf_wr    = (state_q == S_PRSP) && rd_rsp_valid && !rd_rsp_err;
  assign buf_adv   = tx_valid && tx_ready;
  assign retry_inc = (state_q == S_WACK) && ack_valid && !spent &&
                     (ack_code == ACK_BUSY || ack_code == ACK_RETRY);

  atx_payload_buf #(.DW(WORD_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(desc_begin), .wr_en(buf_wr),
    .wr_data(rd_rsp_data), .rewind(retry_inc), .rd_adv(buf_adv),
    .rd_data(buf_q), .wr_idx(wr_idx), .rd_idx(rd_idx));

  atx_retry_ctr #(.RETRY_MAX(RETRY_MAX)) u_retry (
    .clk(clk), .rst_n(rst_n), .clr(desc_begin), .inc(retry_inc),
    .count(retries), .spent(spent));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      dead_q  <= 1'b0;
      irq_q   <= 1'b0;
      desc_q  <= '0;
      ctrl_q  <= '0;
      data_q  <= '0;
      br_q    <= '0;
      widx_q  <= '0;
      len_q   <= '0;
      code_q  <= '0;
    end else begin
      irq_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          dead_q  <= 1'b0;
          desc_q  <= LIST_BASE;
          widx_q  <= '0;
          state_q <= S_DREQ;
        end
        S_DREQ: if (rd_req_ready) state_q <= S_DRSP;
        S_DRSP: if (rd_rsp_valid) begin
          if (rd_rsp_err) begin
            code_q  <= CODE_MEM;
            state_q <= S_WB;
          end else begin
            case (widx_q)
              2'd0:    ctrl_q <= rd_rsp_data;
              2'd1:    data_q <= rd_rsp_data;
              2'd2:    br_q   <= rd_rsp_data;
              default: ;
            endcase
            widx_q <= widx_q + 1'b1;
            if (widx_q != 2'd3) state_q <= S_DREQ;
            else if (len_bad) begin
              code_q  <= CODE_LEN;
              state_q <= S_WB;
            end else begin
              len_q   <= IW'(ctrl_q[CNT_W-1:0]);
              state_q <= S_PREQ;
            end
          end
        end
        S_PREQ: if (rd_req_ready) state_q <= S_PRSP;
        S_PRSP: if (rd_rsp_valid) begin
          if (rd_rsp_err) begin
            code_q  <= CODE_MEM;
            state_q <= S_WB;
          end else if (wr_idx == len_q - 1'b1) state_q <= S_SEND;
          else state_q <= S_PREQ;
        end
        S_SEND: if (tx_ready && tx_last) state_q <= S_WACK;
        S_WACK: if (ack_valid) begin
          case (ack_code)
            ACK_DONE: begin code_q <= CODE_OK;   state_q <= S_WB; end
            ACK_ERR:  begin code_q <= CODE_LINK; state_q <= S_WB; end
            default:
              if (spent) begin code_q <= CODE_RETRY; state_q <= S_WB; end
              else state_q <= S_SEND;
          endcase
        end
        S_WB: if (wr_ready) begin
          irq_q <= 1'b1;
          if (code_q != CODE_OK) begin
            dead_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (desc_begin) begin
            desc_q  <= br_q;
            widx_q  <= '0;
            state_q <= S_DREQ;
          end else state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_data       = '0;
    wr_data[3:0]  = code_q;
    wr_data[15:8] = 8'(retries);
  end

  assign rd_req_valid = (state_q == S_DREQ) || (state_q == S_PREQ);
  assign rd_req_addr  = (state_q == S_DREQ) ? desc_q + {widx_q, 2'b00}
                                            : data_q + (WORD_W'(wr_idx) << 2);
  assign rd_rsp_ready = (state_q == S_DRSP) || (state_q == S_PRSP);
  assign tx_valid     = (state_q == S_SEND);
  assign tx_data      = buf_q;
  assign tx_last      = (rd_idx == len_q - 1'b1);
  assign wr_valid     = (state_q == S_WB);
  assign wr_addr      = desc_q + WORD_W'(12);
  assign irq          = irq_q;
  assign ctx_active   = (state_q != S_IDLE);
  assign ctx_dead     = dead_q;
  assign ctx_idle     = (state_q == S_IDLE) && !dead_q;

  AST_FILL_BEFORE_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (wr_idx == len_q)); // R3
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R13
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr)); // R13
  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_addr)); // R13
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R11
  AST_IRQ_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(wr_valid && wr_ready)); // R11
  AST_DEAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_dead |-> !rd_req_valid && !tx_valid); // R7
  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({ctx_active, ctx_dead, ctx_idle})); // R1
endmodule

// File: tb/atx_ctx_seq_test.sv
`timescale 1ns/1ps
module atx_ctx_seq_test;
  localparam int          DEPTH = 8;
  localparam int          RMAX  = 3;
  localparam logic [31:0] BASE  = 32'h0000_1000;

  logic clk = 0, rst_n = 0, start = 0;
  logic rd_req_valid, rd_req_ready = 0, rd_rsp_valid = 0, rd_rsp_ready, rd_rsp_err = 0;
  logic [31:0] rd_req_addr, rd_rsp_data = 0, tx_data, wr_addr, wr_data;
  logic tx_valid, tx_ready = 0, tx_last, ack_valid = 0, wr_valid, wr_ready = 0;
  logic [1:0] ack_code = 0;
  logic irq, ctx_active, ctx_dead, ctx_idle;

  atx_ctx_seq #(.WORD_W(32), .DEPTH(DEPTH), .RETRY_MAX(RMAX), .LIST_BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .rd_rsp_err(rd_rsp_err), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .ack_valid(ack_valid), .ack_code(ack_code), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq),
    .ctx_active(ctx_active), .ctx_dead(ctx_dead), .ctx_idle(ctx_idle));

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, irq_cnt = 0, exp_irq = 0, ack_cd = 0;
  bit bp = 0, exp_dead = 0, prev_irq = 0;
  logic [31:0] mem [int unsigned];
  bit          errmap [int unsigned];
  logic [31:0] exp_rd [$];
  logic [32:0] exp_tx [$];
  logic [63:0] exp_wr [$];
  int unsigned pend [$];
  int          script [$];
  int          ack_q [$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input int unsigned a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic put_desc(input int unsigned a, input logic [31:0] ctrl, dptr, br, input int seed);
    mem[a] = ctrl; mem[a+4] = dptr; mem[a+8] = br; mem[a+12] = 32'hFFFF_FFFF;
    for (int i = 0; i < ctrl[15:0] && i < 20; i++) mem[dptr + 4*i] = 32'hC0DE_0000 + seed*256 + i;
  endtask

  // behavioural reference: walk the list and the acknowledge script
  task automatic build();
    int unsigned a = BASE;
    int si = 0;
    exp_dead = 0; exp_irq = 0;
    forever begin
      bit err = 0;
      logic [31:0] ctrl, dp, br;
      int n, r, code;
      for (int w = 0; w < 4; w++) begin
        exp_rd.push_back(a + 4*w);
        if (errmap.exists(a + 4*w)) begin err = 1; break; end
      end
      exp_irq++;
      if (err) begin exp_wr.push_back({32'(a+12), 32'h3}); exp_dead = 1; break; end
      ctrl = rd(a); dp = rd(a+4); br = rd(a+8); n = ctrl[15:0];
      if (n == 0 || n > DEPTH) begin exp_wr.push_back({32'(a+12), 32'h5}); exp_dead = 1; break; end
      for (int i = 0; i < n; i++) begin
        exp_rd.push_back(dp + 4*i);
        if (errmap.exists(dp + 4*i)) begin err = 1; break; end
      end
      if (err) begin exp_wr.push_back({32'(a+12), 32'h3}); exp_dead = 1; break; end
      r = 0;
      forever begin
        int c;
        for (int i = 0; i < n; i++) exp_tx.push_back({(i == n-1), rd(dp + 4*i)});
        c = (si < script.size()) ? script[si] : 0; si++;
        if (c == 0) begin code = 1; break; end
        if (c == 3) begin code = 4; break; end
        if (r == RMAX) begin code = 2; break; end
        r++;
      end
      exp_wr.push_back({32'(a+12), 16'h0, 8'(r), 4'h0, 4'(code)});
      if (code != 1) begin exp_dead = 1; break; end
      if (ctrl[31] || br == 0) break;
      a = br;
    end
  endtask

  // stubs and per-clock comparison against the model's predictions
  initial begin
    forever begin
      @(negedge clk); cyc++;
      rd_req_ready = bp ? (cyc % 3 != 0) : 1'b1;
      tx_ready     = bp ? (cyc % 2 == 0) : 1'b1;
      wr_ready     = bp ? (cyc % 3 != 1) : 1'b1;
      if (pend.size() > 0) begin
        rd_rsp_valid = 1; rd_rsp_data = rd(pend[0]); rd_rsp_err = errmap.exists(pend[0]);
      end else begin
        rd_rsp_valid = 0; rd_rsp_data = 0; rd_rsp_err = 0;
      end
      ack_valid = 0;
      if (ack_cd > 0) begin
        ack_cd--;
        if (ack_cd == 0) begin
          ack_valid = 1;
          ack_code = (ack_q.size() > 0) ? 2'(ack_q.pop_front()) : 2'd0;
        end
      end
      #1;
      if (rst_n) begin
        if (rd_req_valid && rd_req_ready) begin
          chk("R2 R3 R7 read order", {32'h0, rd_req_addr},
              exp_rd.size() ? {32'h0, exp_rd.pop_front()} : 64'hDEAD);
          pend.push_back(rd_req_addr);
        end
        if (rd_rsp_valid && rd_rsp_ready) void'(pend.pop_front());
        if (tx_valid && tx_ready) begin
          chk("R3 R5 packet word", {31'h0, tx_last, tx_data},
              exp_tx.size() ? {31'h0, exp_tx.pop_front()} : 64'hDEAD);
          if (tx_last) ack_cd = 2;
        end
        if (wr_valid && wr_ready)
          chk("R4 status write", {wr_addr, wr_data}, exp_wr.size() ? exp_wr.pop_front() : 64'hDEAD);
        if (irq) irq_cnt++;
        if (irq && prev_irq) chk("R11 irq width", 1, 0);
        prev_irq = irq;
        if ($countones({ctx_active, ctx_dead, ctx_idle}) != 1) chk("R1 status bits", 0, 1);
      end
    end
  end

  task automatic run(input string tag, input int spur);
    int n = 0;
    build();
    ack_q = script; irq_cnt = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    if (spur > 0) begin
      repeat (spur) @(negedge clk);
      chk("R12 active before spurious start", ctx_active, 1);
      start = 1; @(negedge clk) start = 0;
    end
    while (ctx_active && n < 3000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    chk({tag, " all predicted events seen"}, exp_rd.size() + exp_tx.size() + exp_wr.size(), 0);
    chk({tag, " dead flag"}, ctx_dead, exp_dead);
    chk({tag, " idle flag"}, ctx_idle, !exp_dead);
    chk({tag, " R11 irq count"}, irq_cnt, exp_irq);
  endtask

  task automatic fresh();
    mem.delete(); errmap.delete(); script.delete(); bp = 0;
  endtask

  initial begin
    int wd = 0;
    fork
      begin
        while (wd < 150000) begin @(negedge clk); wd++; end
        fails++; $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 idle", ctx_idle, 1); chk("R1 active", ctx_active, 0);
    chk("R1 dead", ctx_dead, 0); chk("R1 irq", irq, 0);
    chk("R1 valids", {rd_req_valid, tx_valid, wr_valid}, 0);
    rst_n = 1; repeat (2) @(negedge clk);

    fresh(); put_desc(BASE, 32'h8000_0003, 32'h2000, 32'h0, 1);
    run("R2 R3 R4 single", 0);

    fresh(); put_desc(BASE, 32'h0000_0002, 32'h2000, 32'h1100, 2);
    put_desc(32'h1100, 32'h0000_0008, 32'h2400, 32'h1200, 3);
    put_desc(32'h1200, 32'h0000_0001, 32'h2800, 32'h0, 4);
    bp = 1; run("R10 R13 chain with back-pressure", 0);

    fresh(); put_desc(BASE, 32'h0000_0001, 32'h2000, 32'h1100, 5);
    put_desc(32'h1100, 32'h8000_0001, 32'h2400, 32'h1200, 6);
    put_desc(32'h1200, 32'h0000_0001, 32'h2800, 32'h0, 7);
    run("R10 last flag stops chain", 0);

    fresh(); put_desc(BASE, 32'h8000_0004, 32'h2000, 32'h0, 8);
    script = '{1, 2, 0}; run("R5 retries then done", 0);

    fresh(); put_desc(BASE, 32'h8000_0002, 32'h2000, 32'h0, 9);
    script = '{1, 2, 1, 2}; run("R6 retry exhausted", 0);
    chk("R12 dead before restart", ctx_dead, 1);

    fresh(); put_desc(BASE, 32'h0000_0002, 32'h2000, 32'h1100, 10);
    put_desc(32'h1100, 32'h8000_0002, 32'h2400, 32'h0, 11);
    run("R12 restart clears dead", 0);

    fresh(); put_desc(BASE, 32'h0000_0003, 32'h2000, 32'h1100, 12);
    put_desc(32'h1100, 32'h8000_0001, 32'h2400, 32'h0, 13);
    run("R12 start while active ignored", 5);

    fresh(); put_desc(BASE, 32'h0000_0002, 32'h2000, 32'h1100, 14);
    errmap[BASE + 8] = 1; run("R7 descriptor read error", 0);

    fresh(); put_desc(BASE, 32'h0000_0005, 32'h2000, 32'h1100, 15);
    put_desc(32'h1100, 32'h8000_0001, 32'h2400, 32'h0, 16);
    errmap[32'h2008] = 1; run("R7 payload read error", 0);

    fresh(); put_desc(BASE, 32'h8000_0002, 32'h2000, 32'h0, 17);
    script = '{2, 3}; run("R8 link error", 0);

    fresh(); put_desc(BASE, 32'h8000_0000, 32'h2000, 32'h0, 18);
    run("R9 zero count", 0);

    fresh(); put_desc(BASE, 32'h8000_0000 | DEPTH+1, 32'h2000, 32'h0, 19);
    run("R9 count above depth", 0);

    fresh(); put_desc(BASE, 32'h8000_0000 | DEPTH, 32'h2000, 32'h0, 20);
    bp = 1; run("R3 full-depth payload", 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule